// File: doc/BRIEF.md
# Spatial Region Pattern Accumulator

This block tracks the active spatial regions of a cache. A region is an aligned power-of-two span of 64-byte lines. For each active region it records which lines were touched since the region was first accessed. That record is called a generation. Training accesses come from the cache: demand misses, and hits to lines that a prefetch brought in. The first training access to a region with no entry opens a generation. The entry stores the access's program counter as the learning key and a rotation amount. The rotation makes the opening (trigger) line land in pattern bit 0. Later training accesses to the region OR in their rotated bit.

A generation ends in one of two ways. The first is an eviction notice for a line whose bit is already set in the pattern. The second is a new region that needs a slot while the table is full; in that case the least-recently-used entry is displaced. Either way the finished pattern and its key appear on the learned-pattern output for one cycle, for a downstream pattern store.

A build-time option turns rotation off. Bits then sit at the raw line offset, and the key becomes the program counter joined with the trigger's line offset.

Top module: `region_pattern_acc`

## Requirements
- R1: After reset `learn_valid_o` and `same_bit_o` are low, and an eviction notice to an empty table produces no learned pattern.
- R2: A training access (`acc_valid_i` with `acc_miss_i` or `acc_pf_i` high) to a region without an entry opens a generation keyed by `acc_pc_i`, with only pattern bit 0 set. The region tag is `addr[ADDR_W-1:REGION_SHIFT]` and the line offset is `addr[REGION_SHIFT-1:6]`.
- R3: A later training access at line offset `o` to a region opened at trigger offset `t` sets pattern bit `(o - t) mod BLOCKS`.
- R4: An eviction notice for a line whose bit is set in an active entry removes the entry. On the next cycle `learn_valid_o` pulses for one cycle with that entry's key on `learn_key_o` and its pattern on `learn_pattern_o`.
- R5: An eviction notice for a line in an inactive region, or for a line whose bit is clear, produces no learned pattern and leaves the entry open.
- R6: An access with both `acc_miss_i` and `acc_pf_i` low changes no entry.
- R7: A hit to a prefetched line (`acc_pf_i` high, `acc_miss_i` low) trains like a miss.
- R8: A training miss on a line whose bit is already set pulses `same_bit_o` on the next cycle. The generation stays open.
- R9: A new region arriving while all ENTRIES slots are valid displaces the least-recently-used entry and emits its key and pattern on the next cycle. While a free slot exists, allocation emits nothing.
- R10: Every training access to an existing entry makes that entry the most recently used.
- R11: With ROTATE = 0, an access at line offset `o` sets bit `o`. The key is `{pc, trigger_offset}`, with the program counter in the upper bits.
- R12: An eviction notice and a training access may target the same region in one cycle. If the notice closes the entry, the old generation is emitted and the access opens a fresh generation in its place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Cache access present |
| acc_addr_i | input | ADDR_W | Access byte address |
| acc_pc_i | input | PC_W | Program counter of the access |
| acc_miss_i | input | 1 | Access missed the cache |
| acc_pf_i | input | 1 | Access hit a line brought in by a prefetch |
| evict_valid_i | input | 1 | Eviction notice present |
| evict_addr_i | input | ADDR_W | Address of the evicted line |
| learn_valid_o | output | 1 | Finished generation present |
| learn_key_o | output | KEY_W | Learning key of the finished generation |
| learn_pattern_o | output | BLOCKS | Finished footprint pattern |
| same_bit_o | output | 1 | Training miss hit an already-set bit |

## Verification
One region is given a trigger followed by misses both above and below the trigger offset. A pattern bit past the wrap point shows that rotation is taken modulo the region size, not clamped. The bench also mixes in plain hits and prefetched hits. It then issues eviction notices to the plain-hit line and to an unrecorded line, and neither may close the generation. This separates the training filter from the close test. Filling every slot and then touching the oldest entry shows that the displaced entry follows use order rather than insertion order. A same-cycle eviction and re-access of one region, together with a second instance with rotation disabled, show that the key and bit placement follow the chosen variant.

// File: rtl/rpa_pkg.sv
package rpa_pkg;
  typedef enum logic [1:0] {
    EMIT_NONE,
    EMIT_CLOSE,
    EMIT_VICTIM
  } emit_src_e;
endpackage

// File: rtl/rpa_match.sv
module rpa_match #(
  parameter int N     = 32,
  parameter int TAG_W = 20,
  parameter int OFF_W = 6,
  localparam int BLOCKS = 1 << OFF_W
) (
  input  logic [N-1:0]             valid_i,
  input  logic [N-1:0][TAG_W-1:0]  tag_i,
  input  logic [N-1:0][OFF_W-1:0]  rot_i,
  input  logic [N-1:0][BLOCKS-1:0] pat_i,
  input  logic [TAG_W-1:0]         acc_tag_i,
  input  logic [OFF_W-1:0]         acc_off_i,
  input  logic [TAG_W-1:0]         ev_tag_i,
  input  logic [OFF_W-1:0]         ev_off_i,
  output logic [N-1:0]             acc_hit_o,
  output logic [N-1:0]             acc_set_o,
  output logic [N-1:0]             ev_close_o
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    logic [OFF_W-1:0] acc_bit, ev_bit;
    assign acc_bit       = acc_off_i + rot_i[g];
    assign ev_bit        = ev_off_i + rot_i[g];
    assign acc_hit_o[g]  = valid_i[g] && (tag_i[g] == acc_tag_i);
    assign acc_set_o[g]  = pat_i[g][acc_bit];
    assign ev_close_o[g] = valid_i[g] && (tag_i[g] == ev_tag_i) && pat_i[g][ev_bit];
  end
endmodule

// File: rtl/rpa_lru.sv
module rpa_lru #(
  parameter int N = 32,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [IDX_W-1:0] victim_o
);
  logic [N-1:0][IDX_W-1:0] rank_q;
  logic [N-1:0]            oldest;

  // rank 0 = most recent; ranks always form a permutation
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) rank_q[i] <= IDX_W'(i);
    end else if (touch_i) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == touch_idx_i) rank_q[i] <= '0;
        else if (rank_q[i] < rank_q[touch_idx_i]) rank_q[i] <= rank_q[i] + IDX_W'(1);
      end
    end
  end

  always_comb begin
    victim_o = '0;
    for (int i = 0; i < N; i++) begin
      oldest[i] = (rank_q[i] == IDX_W'(N - 1));
      if (oldest[i]) victim_o = IDX_W'(i);
    end
  end

  assert_rank_perm_R10: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot(oldest));
  assert_touch_newest_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> rank_q[$past(touch_idx_i)] == '0);
endmodule

// File: rtl/region_pattern_acc.sv
module region_pattern_acc
  import rpa_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int PC_W         = 16,
  parameter int REGION_SHIFT = 12,
  parameter int ENTRIES      = 32,
  parameter bit ROTATE       = 1'b1,
  localparam int LINE_SHIFT = 6,
  localparam int OFF_W      = REGION_SHIFT - LINE_SHIFT,
  localparam int BLOCKS     = 1 << OFF_W,
  localparam int TAG_W      = ADDR_W - REGION_SHIFT,
  localparam int KEY_W      = ROTATE ? PC_W : PC_W + OFF_W,
  localparam int IDX_W      = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [PC_W-1:0]   acc_pc_i,
  input  logic              acc_miss_i,
  input  logic              acc_pf_i,
  input  logic              evict_valid_i,
  input  logic [ADDR_W-1:0] evict_addr_i,
  output logic              learn_valid_o,
  output logic [KEY_W-1:0]  learn_key_o,
  output logic [BLOCKS-1:0] learn_pattern_o,
  output logic              same_bit_o
);
  localparam int N = ENTRIES;

  logic [N-1:0]             valid_q;
  logic [N-1:0][TAG_W-1:0]  tag_q;
  logic [N-1:0][KEY_W-1:0]  key_q;
  logic [N-1:0][OFF_W-1:0]  rot_q;
  logic [N-1:0][BLOCKS-1:0] pat_q;

  logic [TAG_W-1:0] acc_tag, ev_tag;
  logic [OFF_W-1:0] acc_off, ev_off;
  logic             trn;
  logic [N-1:0]     acc_hit, acc_set, ev_close, hit_v, close_v;

  assign trn     = acc_valid_i && (acc_miss_i || acc_pf_i);
  assign acc_tag = acc_addr_i[ADDR_W-1:REGION_SHIFT];
  assign acc_off = acc_addr_i[REGION_SHIFT-1:LINE_SHIFT];
  assign ev_tag  = evict_addr_i[ADDR_W-1:REGION_SHIFT];
  assign ev_off  = evict_addr_i[REGION_SHIFT-1:LINE_SHIFT];

  logic unused_low;
  assign unused_low = ^{acc_addr_i[LINE_SHIFT-1:0], evict_addr_i[LINE_SHIFT-1:0]};

  rpa_match #(.N(N), .TAG_W(TAG_W), .OFF_W(OFF_W)) u_match (
    .valid_i   (valid_q),
    .tag_i     (tag_q),
    .rot_i     (rot_q),
    .pat_i     (pat_q),
    .acc_tag_i (acc_tag),
    .acc_off_i (acc_off),
    .ev_tag_i  (ev_tag),
    .ev_off_i  (ev_off),
    .acc_hit_o (acc_hit),
    .acc_set_o (acc_set),
    .ev_close_o(ev_close)
  );

  assign hit_v   = acc_hit & {N{trn}};
  assign close_v = ev_close & {N{evict_valid_i}};

  logic             acc_any, close_any, free_any;
  logic [IDX_W-1:0] acc_idx, close_idx, free_idx, lru_idx;

  always_comb begin
    acc_idx   = '0;
    close_idx = '0;
    free_idx  = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_v[i])   acc_idx   = IDX_W'(i);
      if (close_v[i]) close_idx = IDX_W'(i);
    end
    for (int i = N - 1; i >= 0; i--) if (!valid_q[i]) free_idx = IDX_W'(i);
  end
  assign acc_any   = |hit_v;
  assign close_any = |close_v;
  assign free_any  = ~&valid_q;

  // slot choice: own entry, else free slot, else slot freed this cycle, else LRU
  logic             alloc, reopen, open, victim_emit;
  logic [IDX_W-1:0] slot, emit_idx;
  emit_src_e        emit_src;

  assign alloc       = trn && !acc_any;
  assign reopen      = acc_any && close_any && (close_idx == acc_idx);
  assign open        = alloc || reopen;
  assign victim_emit = alloc && !free_any && !close_any;

  always_comb begin
    if (acc_any)        slot = acc_idx;
    else if (free_any)  slot = free_idx;
    else if (close_any) slot = close_idx;
    else                slot = lru_idx;
  end

  always_comb begin
    if (close_any)        emit_src = EMIT_CLOSE;
    else if (victim_emit) emit_src = EMIT_VICTIM;
    else                  emit_src = EMIT_NONE;
    emit_idx = (emit_src == EMIT_CLOSE) ? close_idx : lru_idx;
  end

  rpa_lru #(.N(N)) u_lru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .touch_i    (trn),
    .touch_idx_i(slot),
    .victim_o   (lru_idx)
  );

  logic [KEY_W-1:0]  new_key;
  logic [OFF_W-1:0]  new_rot, upd_rot, bit_idx;
  logic [BLOCKS-1:0] bit_vec;

  if (ROTATE) begin : g_rot
    assign new_key = acc_pc_i;
    assign new_rot = ~acc_off + OFF_W'(1);
  end else begin : g_raw
    assign new_key = {acc_pc_i, acc_off};
    assign new_rot = '0;
  end

  assign upd_rot = open ? new_rot : rot_q[slot];
  assign bit_idx = acc_off + upd_rot;
  assign bit_vec = BLOCKS'(1) << bit_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q         <= '0;
      tag_q           <= '0;
      key_q           <= '0;
      rot_q           <= '0;
      pat_q           <= '0;
      learn_valid_o   <= 1'b0;
      learn_key_o     <= '0;
      learn_pattern_o <= '0;
      same_bit_o      <= 1'b0;
    end else begin
      if (close_any) valid_q[close_idx] <= 1'b0;
      if (open) begin
        valid_q[slot] <= 1'b1;
        tag_q[slot]   <= acc_tag;
        key_q[slot]   <= new_key;
        rot_q[slot]   <= new_rot;
        pat_q[slot]   <= bit_vec;
      end else if (acc_any) begin
        pat_q[slot] <= pat_q[slot] | bit_vec;
      end
      learn_valid_o   <= (emit_src != EMIT_NONE);
      learn_key_o     <= key_q[emit_idx];
      learn_pattern_o <= pat_q[emit_idx];
      same_bit_o      <= acc_any && !reopen && acc_miss_i && acc_set[acc_idx];
    end
  end

  assert_one_close_R4: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(close_v));
  assert_one_owner_R3: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(hit_v));
  assert_learn_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    learn_valid_o |-> $past(evict_valid_i || trn));
  assert_victim_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (learn_valid_o && !$past(evict_valid_i)) |-> $past(&valid_q));
  assert_plain_hit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_miss_i && !acc_pf_i && !evict_valid_i) |=> (!learn_valid_o && !same_bit_o && $stable(pat_q)));
  assert_same_bit_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    same_bit_o |-> $past(acc_valid_i && acc_miss_i));
endmodule

// File: tb/region_pattern_acc_bench.sv
`timescale 1ns/1ps
module region_pattern_acc_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_valid_i = 1'b0, acc_miss_i = 1'b0, acc_pf_i = 1'b0;
  logic [31:0] acc_addr_i = '0, evict_addr_i = '0;
  logic [15:0] acc_pc_i = '0;
  logic        evict_valid_i = 1'b0;
  logic        lv, sb, rv, rsb;
  logic [15:0] lk;
  logic [21:0] rk;
  logic [63:0] lp, rp;
  int checks = 0, errors = 0;

  always #2.5 clk_i = ~clk_i;

  region_pattern_acc u_region_pattern_acc (
    .clk_i, .rst_ni, .acc_valid_i, .acc_addr_i, .acc_pc_i, .acc_miss_i, .acc_pf_i,
    .evict_valid_i, .evict_addr_i,
    .learn_valid_o(lv), .learn_key_o(lk), .learn_pattern_o(lp), .same_bit_o(sb)
  );

  region_pattern_acc #(.ROTATE(1'b0)) u_region_pattern_acc_raw (
    .clk_i, .rst_ni, .acc_valid_i, .acc_addr_i, .acc_pc_i, .acc_miss_i, .acc_pf_i,
    .evict_valid_i, .evict_addr_i,
    .learn_valid_o(rv), .learn_key_o(rk), .learn_pattern_o(rp), .same_bit_o(rsb)
  );

  function automatic logic [31:0] mk(input int tag, input int off);
    return {tag[19:0], off[5:0], 6'h0};
  endfunction

  function automatic logic [63:0] rb(input int off, input int trig);
    return 64'd1 << ((off - trig) & 63);
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one cycle: inputs captured at the edge, registered outputs read just after it
  task automatic drive(input bit av, input int atag, input int aoff, input int pc,
                       input bit miss, input bit pf, input bit ev, input int etag, input int eoff);
    acc_valid_i   = av;
    acc_addr_i    = mk(atag, aoff);
    acc_pc_i      = pc[15:0];
    acc_miss_i    = miss;
    acc_pf_i      = pf;
    evict_valid_i = ev;
    evict_addr_i  = mk(etag, eoff);
    @(posedge clk_i);
    #1;
    acc_valid_i   = 1'b0;
    evict_valid_i = 1'b0;
  endtask

  task automatic acc(input int tag, input int off, input int pc, input bit miss, input bit pf);
    drive(1'b1, tag, off, pc, miss, pf, 1'b0, 0, 0);
  endtask

  task automatic evict(input int tag, input int off);
    drive(1'b0, 0, 0, 0, 1'b0, 1'b0, 1'b1, tag, off);
  endtask

  task automatic t_reset;
    check("R1", "learn after reset", 64'(lv), 64'd0);
    check("R1", "same_bit after reset", 64'(sb), 64'd0);
    evict(7, 3);
    check("R1", "evict on empty table", 64'(lv), 64'd0);
  endtask

  task automatic t_basic;
    logic [63:0] exp;
    acc(1, 10, 'h111, 1'b1, 1'b0);
    check("R2", "no emit on open", 64'(lv), 64'd0);
    acc(1, 12, 'h111, 1'b1, 1'b0);
    acc(1, 5, 'h111, 1'b1, 1'b0);
    acc(1, 20, 'h111, 1'b0, 1'b0);
    check("R6", "plain hit no same_bit", 64'(sb), 64'd0);
    acc(1, 3, 'h111, 1'b0, 1'b1);
    evict(1, 20);
    check("R6", "plain-hit line not recorded", 64'(lv), 64'd0);
    evict(1, 30);
    check("R5", "clear bit keeps gen", 64'(lv), 64'd0);
    evict(9, 12);
    check("R5", "inactive region", 64'(lv), 64'd0);
    evict(1, 12);
    exp = rb(10, 10) | rb(12, 10) | rb(5, 10) | rb(3, 10);
    check("R4", "close valid", 64'(lv), 64'd1);
    check("R2", "key is trigger pc", 64'(lk), 64'h111);
    check("R3", "rotated pattern", lp, exp);
    check("R7", "prefetch-hit bit present", lp & rb(3, 10), rb(3, 10));
    evict(1, 12);
    check("R4", "entry removed", 64'(lv), 64'd0);
  endtask

  task automatic t_same_bit;
    acc(2, 0, 'h222, 1'b1, 1'b0);
    acc(2, 4, 'h222, 1'b1, 1'b0);
    check("R8", "first touch no same_bit", 64'(sb), 64'd0);
    acc(2, 4, 'h222, 1'b1, 1'b0);
    check("R8", "same_bit pulse", 64'(sb), 64'd1);
    check("R8", "gen stays open", 64'(lv), 64'd0);
    acc(2, 7, 'h222, 1'b0, 1'b1);
    check("R8", "pulse is one cycle", 64'(sb), 64'd0);
    evict(2, 0);
    check("R8", "close after same_bit", 64'(lv), 64'd1);
    check("R8", "pattern", lp, rb(0, 0) | rb(4, 0) | rb(7, 0));
  endtask

  task automatic t_lru;
    int emits = 0;
    for (int i = 0; i < 32; i++) begin
      acc(100 + i, 0, 'h300 + i, 1'b1, 1'b0);
      if (lv) emits++;
    end
    check("R9", "no emit while free slot", 64'(emits), 64'd0);
    acc(100, 1, 'h300, 1'b1, 1'b0);
    acc(200, 0, 'h400, 1'b1, 1'b0);
    check("R9", "victim emitted", 64'(lv), 64'd1);
    check("R10", "victim is LRU not touched", 64'(lk), 64'h301);
    check("R9", "victim pattern", lp, 64'd1);
    acc(201, 0, 'h401, 1'b1, 1'b0);
    check("R9", "next victim", 64'(lk), 64'h302);
  endtask

  task automatic t_same_cycle;
    drive(1'b1, 100, 9, 'h3AA, 1'b1, 1'b0, 1'b1, 100, 1);
    check("R12", "old gen emitted", 64'(lv), 64'd1);
    check("R12", "old key", 64'(lk), 64'h300);
    check("R12", "old pattern", lp, rb(0, 0) | rb(1, 0));
    evict(100, 9);
    check("R12", "fresh gen key", 64'(lk), 64'h3AA);
    check("R12", "fresh gen pattern", lp, 64'd1);
  endtask

  task automatic t_raw;
    acc(5, 10, 'h55, 1'b1, 1'b0);
    acc(5, 12, 'h55, 1'b1, 1'b0);
    evict(5, 12);
    check("R11", "raw close", 64'(rv), 64'd1);
    check("R11", "raw key", 64'(rk), (64'h55 << 6) | 64'd10);
    check("R11", "raw pattern", rp, (64'd1 << 10) | (64'd1 << 12));
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    t_reset();
    t_basic();
    t_same_bit();
    t_lru();
    t_same_cycle();
    t_raw();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule